// File: doc/BRIEF.md
# Stepped LED Brightness Fade Controller

This block keeps the 5-bit brightness code that sets the current of four LED sinks. Software writes a target code along with a fade-enable bit and a 2-bit step rate. When fading is off, the applied code takes the target at once. When fading is on, the applied code moves one count at a time toward the target. Each move happens after a set number of millisecond ticks, and the rate field selects that number.

While a fade runs, the block refuses a new target. A write made during the fade still updates the fade-enable bit and the rate. Clearing fade-enable ends the fade and the applied code jumps to the stored target. A new rate takes over the remaining steps and the fade does not restart.

A separate write sets the four channel enables. The block raises a sleep request when all four enables are zero. It raises a low-current flag when the applied code is small. Turning codes into analog current is left to the sinks.

Top module: `led_fade_ctrl`

## Requirements
- R1: The step interval in `ms_tick_i` pulses is set by `rate_i`: 0 gives 32, 1 gives 24, 2 gives 16 and 3 gives 8. The first step of a fade lands on the pulse that completes the first full interval after the target write.
- R2: When fading, `level_o` changes by exactly one count per interval toward the target and stops when it equals the target. The number of steps equals the absolute difference between the old code and the new one, so a 0 to 31 fade at rate 0 takes 31 x 32 = 992 ticks.
- R3: A brightness write made while `busy_o` is high leaves the stored target unchanged. The fade keeps heading to the earlier target.
- R4: A brightness write with `fade_en_i` = 0 made while `busy_o` is high sets `level_o` to the stored target on the next cycle, and `busy_o` falls.
- R5: A brightness write made during a fade replaces the rate for the remaining steps. The tick count already gathered toward the current step is kept and checked against the new interval.
- R6: A brightness write with `fade_en_i` = 0 made while idle sets `level_o` to `target_i` on the next cycle.
- R7: After reset, `level_o` is 0, `chan_en_o` is 0, `busy_o` is 0, `sleep_req_o` is 1 and `low_cur_o` is 1.
- R8: `busy_o` is high exactly while the applied code differs from the stored target.
- R9: `sleep_req_o` is high exactly when all four bits of `chan_en_o` are zero.
- R10: `low_cur_o` is high exactly when `level_o` is 7 or less.
- R11: A channel write sets `chan_en_o` to `chan_i` on the next cycle. This does not depend on any fade in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bright_we_i | input | 1 | Brightness register write strobe |
| target_i | input | 5 | Requested brightness code |
| fade_en_i | input | 1 | Fade enable written with the brightness register |
| rate_i | input | 2 | Step rate code written with the brightness register |
| chan_we_i | input | 1 | Channel enable write strobe |
| chan_i | input | 4 | Channel enables to write |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| level_o | output | 5 | Applied brightness code |
| chan_en_o | output | 4 | Per-channel enables |
| busy_o | output | 1 | Fade in progress |
| sleep_req_o | output | 1 | All channels disabled |
| low_cur_o | output | 1 | Applied code at or below the low-current limit |

## Verification
The bench tries direct writes both upward and downward. These show that an immediate jump is separate from a one-step move. It runs fades at all four rates and checks the tick count just before and just after each step, which tells a correct interval apart from one that is off by one tick. A new target written during a fade shows whether the lockout holds. An abort shows whether the code lands on the stored target or on the written one. A rate change made after part of an interval has passed shows whether the tick count is kept or reset. A full-scale fade at the slowest rate covers the longest count.

// File: rtl/led_fade_pkg.sv
package led_fade_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW   = 2'd0,
    RATE_MID_LO = 2'd1,
    RATE_MID_HI = 2'd2,
    RATE_FAST   = 2'd3
  } rate_e;

  // interval length in units: rate 0 -> 4 units, rate 3 -> 1 unit
  function automatic int unsigned rate_units(rate_e r);
    return 32'd4 - 32'(r);
  endfunction

endpackage

// File: rtl/led_fade_timer.sv
module led_fade_timer
  import led_fade_pkg::*;
#(
  parameter int unsigned UNIT_MS = 8,
  parameter int unsigned CNT_W   = 6
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hold_i,
  input  logic  tick_i,
  input  rate_e rate_i,
  output logic  step_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   cnt_inc;

  assign limit   = CNT_W'(rate_units(rate_i) * UNIT_MS);
  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  // compare against the live rate so a mid-fade change applies to the running count
  assign step_o  = tick_i && !hold_i && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (hold_i)  cnt_q <= '0;
    else if (step_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_inc[CNT_W-1:0];
  end

endmodule

// File: rtl/led_fade_level.sv
module led_fade_level #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic              fade_en_i,
  input  logic              step_i,
  output logic [CODE_W-1:0] level_o,
  output logic [CODE_W-1:0] target_o,
  output logic              busy_o
);

  logic [CODE_W-1:0] level_q, target_q;
  logic [CODE_W-1:0] jump_to;

  assign busy_o   = (level_q != target_q);
  assign jump_to  = busy_o ? target_q : target_i;
  assign level_o  = level_q;
  assign target_o = target_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
    end else if (we_i && !busy_o) begin
      target_q <= target_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
    end else if (we_i && !fade_en_i) begin
      level_q <= jump_to;
    end else if (step_i) begin
      if (level_q < target_q) level_q <= level_q + CODE_W'(1);
      else                    level_q <= level_q - CODE_W'(1);
    end
  end

endmodule

// File: rtl/led_fade_chan.sv
module led_fade_chan #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] en_o
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q <= 1'b0;
      else if (we_i) en_q <= en_i[g];
    end
    assign en_o[g] = en_q;
  end

endmodule

// File: rtl/led_fade_ctrl.sv
module led_fade_ctrl
  import led_fade_pkg::*;
#(
  parameter int unsigned CODE_W  = 5,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned UNIT_MS = 8,
  parameter int unsigned LOW_MAX = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bright_we_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic              fade_en_i,
  input  logic [1:0]        rate_i,
  input  logic              chan_we_i,
  input  logic [NUM_CH-1:0] chan_i,
  input  logic              ms_tick_i,
  output logic [CODE_W-1:0] level_o,
  output logic [NUM_CH-1:0] chan_en_o,
  output logic              busy_o,
  output logic              sleep_req_o,
  output logic              low_cur_o
);

  localparam int unsigned CNT_W = $clog2(4 * UNIT_MS + 1);

  rate_e             rate_q;
  logic              fade_en_q;
  logic              step;
  logic [CODE_W-1:0] target_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q    <= RATE_SLOW;
      fade_en_q <= 1'b0;
    end else if (bright_we_i) begin
      rate_q    <= rate_e'(rate_i);
      fade_en_q <= fade_en_i;
    end
  end

  led_fade_timer #(.UNIT_MS(UNIT_MS), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (!busy_o || !fade_en_q),
    .tick_i (ms_tick_i),
    .rate_i (rate_q),
    .step_o (step)
  );

  led_fade_level #(.CODE_W(CODE_W)) u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bright_we_i),
    .target_i  (target_i),
    .fade_en_i (fade_en_i),
    .step_i    (step),
    .level_o   (level_o),
    .target_o  (target_q),
    .busy_o    (busy_o)
  );

  led_fade_chan #(.NUM_CH(NUM_CH)) u_chan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (chan_we_i),
    .en_i   (chan_i),
    .en_o   (chan_en_o)
  );

  assign sleep_req_o = ~|chan_en_o;
  assign low_cur_o   = (level_o <= CODE_W'(LOW_MAX));

endmodule

// File: rtl/led_fade_ctrl_chk.sv
module led_fade_ctrl_chk #(
  parameter int unsigned CODE_W = 5,
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bright_we_i,
  input logic [CODE_W-1:0] target_i,
  input logic              fade_en_i,
  input logic              chan_we_i,
  input logic [NUM_CH-1:0] chan_i,
  input logic [CODE_W-1:0] level_o,
  input logic [NUM_CH-1:0] chan_en_o,
  input logic              busy_o,
  input logic [CODE_W-1:0] target_q
);

  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bright_we_i |=> (level_o == $past(level_o)) ||
      ({1'b0, level_o} == {1'b0, $past(level_o)} + (CODE_W+1)'(1)) ||
      ({1'b0, level_o} + (CODE_W+1)'(1) == {1'b0, $past(level_o)}));

  assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bright_we_i && !busy_o |=> $stable(level_o));

  assert_retarget_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && bright_we_i |=> target_q == $past(target_q));

  assert_abort_jump_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && bright_we_i && !fade_en_i |=> !busy_o && level_o == $past(target_q));

  assert_direct_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && bright_we_i && !fade_en_i |=> level_o == $past(target_i));

  assert_chan_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_we_i |=> chan_en_o == $past(chan_i));

endmodule

bind led_fade_ctrl led_fade_ctrl_chk #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/led_fade_ctrl_bench.sv
module led_fade_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bright_we = 1'b0;
  logic [4:0] target = '0;
  logic       fade_en = 1'b0;
  logic [1:0] rate = '0;
  logic       chan_we = 1'b0;
  logic [3:0] chan = '0;
  logic       tick = 1'b0;
  logic [4:0] level;
  logic [3:0] chan_en;
  logic       busy, sleep_req, low_cur;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  led_fade_ctrl u_led_fade_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bright_we_i(bright_we), .target_i(target),
    .fade_en_i(fade_en), .rate_i(rate), .chan_we_i(chan_we), .chan_i(chan),
    .ms_tick_i(tick), .level_o(level), .chan_en_o(chan_en), .busy_o(busy),
    .sleep_req_o(sleep_req), .low_cur_o(low_cur)
  );

  // behavioural reference model
  int m_level = 0, m_target = 0, m_rate = 0, m_chan = 0, m_cnt = 0;
  bit m_fade = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_level = 0; m_target = 0; m_rate = 0; m_chan = 0; m_cnt = 0; m_fade = 0;
    end else begin
      bit moving, do_step;
      moving  = (m_level != m_target) && m_fade;
      do_step = 0;
      if (moving && tick) begin
        if (m_cnt + 1 >= 8 * (4 - m_rate)) begin do_step = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end else if (!moving) m_cnt = 0;
      if (bright_we && !fade_en)
        m_level = (m_level != m_target) ? m_target : int'(target);
      else if (do_step)
        m_level = (m_level < m_target) ? m_level + 1 : m_level - 1;
      if (bright_we) begin
        if (!(m_level != m_target) || !(moving || (m_level != m_target)))
          ;
      end
      if (bright_we) begin
        m_fade = fade_en;
        m_rate = int'(rate);
      end
      if (chan_we) m_chan = int'(chan);
    end
  end

  // target update kept apart so the busy test uses the pre-edge code
  int m_prev_level = 0, m_prev_target = 0;
  always @(negedge clk) begin
    m_prev_level  <= int'(level);
    m_prev_target <= m_target;
  end

  always @(posedge clk) begin
    if (rst_n && bright_we && (m_prev_level == m_prev_target)) m_target = int'(target);
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 level", int'(level), m_level);
      chk("R8 busy", int'(busy), int'(m_level != m_target));
      chk("R11 chan", int'(chan_en), m_chan);
      chk("R9 sleep", int'(sleep_req), int'(m_chan == 0));
      chk("R10 low", int'(low_cur), int'(m_level <= 7));
    end
  end

  task automatic wr_bright(input int t, input bit fe, input int r);
    @(negedge clk);
    bright_we = 1'b1; target = 5'(t); fade_en = fe; rate = 2'(r);
    @(negedge clk);
    bright_we = 1'b0;
  endtask

  task automatic wr_chan(input int c);
    @(negedge clk);
    chan_we = 1'b1; chan = 4'(c);
    @(negedge clk);
    chan_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 level", int'(level), 0);
    chk("R7 chan", int'(chan_en), 0);
    chk("R7 busy", int'(busy), 0);
    chk("R7 sleep", int'(sleep_req), 1);
    chk("R7 low", int'(low_cur), 1);
    rst_n = 1'b1;

    wr_chan(4'b0101);
    chk("R11 chan write", int'(chan_en), 5);
    chk("R9 awake", int'(sleep_req), 0);

    wr_bright(20, 0, 0);
    chk("R6 jump up", int'(level), 20);
    chk("R10 high code", int'(low_cur), 0);
    wr_bright(5, 0, 0);
    chk("R6 jump down", int'(level), 5);
    chk("R10 low code", int'(low_cur), 1);

    wr_bright(8, 1, 3);
    chk("R8 busy start", int'(busy), 1);
    ticks(7);
    chk("R1 rate3 before", int'(level), 5);
    ticks(1);
    chk("R1 rate3 step", int'(level), 6);
    ticks(16);
    chk("R2 arrived", int'(level), 8);
    chk("R8 idle", int'(busy), 0);

    wr_bright(7, 1, 0);
    ticks(31);
    chk("R1 rate0 before", int'(level), 8);
    ticks(1);
    chk("R1 rate0 step", int'(level), 7);

    wr_bright(9, 1, 1);
    ticks(23);
    chk("R1 rate1 before", int'(level), 7);
    ticks(1);
    chk("R1 rate1 step", int'(level), 8);
    wr_bright(9, 1, 2);
    ticks(15);
    chk("R1 rate2 before", int'(level), 8);
    ticks(1);
    chk("R1 rate2 step", int'(level), 9);

    wr_bright(0, 1, 3);
    ticks(8);
    chk("R2 down step", int'(level), 8);
    wr_bright(30, 1, 3);
    ticks(8);
    chk("R3 target locked", int'(level), 7);
    wr_chan(4'b0000);
    chk("R9 sleep", int'(sleep_req), 1);
    chk("R11 during fade", int'(chan_en), 0);

    wr_bright(25, 0, 3);
    chk("R4 abort level", int'(level), 0);
    chk("R4 abort busy", int'(busy), 0);

    wr_bright(2, 1, 0);
    ticks(20);
    wr_bright(0, 1, 3);
    ticks(1);
    chk("R5 kept count", int'(level), 1);
    ticks(7);
    chk("R5 new rate before", int'(level), 1);
    ticks(1);
    chk("R5 new rate step", int'(level), 2);

    wr_bright(0, 0, 0);
    wr_bright(31, 1, 0);
    ticks(991);
    chk("R2 full scale before", int'(level), 30);
    ticks(1);
    chk("R2 full scale end", int'(level), 31);
    chk("R8 full scale idle", int'(busy), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule